// File: doc/BRIEF.md
# Dual-SRAM Display Memory Interface

This block sits between a display controller's internal request port and two external byte-wide SRAMs. Together the two SRAMs form one 16-bit display memory. The even-byte SRAM connects to data bits 7:0 and the odd-byte SRAM connects to data bits 15:8. Both SRAMs share one 16-bit word address. Each SRAM has its own active-low chip select. The two SRAMs share an active-low write strobe and an active-low read strobe.

A request carries a direction, a word address, two byte enables and write data. The block accepts a request only while it is idle. It then runs the memory access for a fixed number of clock cycles, set by `ACC_CYCLES`. It finishes with a one-cycle done pulse that carries the read data. Only the lanes named by the byte enables take part in the access.

The bidirectional data bus is split at the pads into an input, an output and an output enable. While reset is high the block releases the bus. During that time the bus carries strap levels that select hardware options. The value present when reset falls is kept in a configuration register until the next reset.

Top module: `dispmem_sram_if`

## Requirements
- R1: Bits 7:0 of the data bus carry the even byte and bits 15:8 carry the odd byte. Write data bit i appears on bus bit i, and read data bit i comes from bus bit i.
- R2: During an access, the even chip select is low exactly when byte enable bit 0 is set, and the odd chip select is low exactly when byte enable bit 1 is set. Outside an access, both chip selects are high.
- R3: The write strobe is low only during write accesses, and the read strobe is low only during read accesses. The two strobes are never low in the same cycle.
- R4: The bus output enable is high only while a write access is in progress. It is low for every cycle in which reset is high.
- R5: The configuration output equals the data bus value sampled at the last rising clock edge at which reset was high.
- R6: After reset is released, the configuration output does not change, whatever traffic crosses the data bus.
- R7: An accepted access drives the memory strobes for exactly `ACC_CYCLES` cycles. It is followed by `done` high for exactly one cycle.
- R8: At `done`, `rdata` holds the bus value sampled in the last access cycle for each enabled lane. A disabled lane reads as zero. `rdata` is zero after a write.
- R9: A request with both byte enables clear is ignored. It produces no strobe, no chip select and no `done`.
- R10: The address bus holds the request's word address, unchanged, for the whole access.
- R11: `req_ready` is low while an access is in progress and high otherwise (outside reset). A request presented in the cycle of `done` is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; also the strap capture window |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_be | input | 2 | Byte enables: bit 0 even lane, bit 1 odd lane |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Block idle and able to accept |
| done | output | 1 | One-cycle access completion |
| rdata | output | 16 | Read data, valid with done |
| mem_addr | output | 16 | SRAM address bus |
| mem_din | input | 16 | Data bus as seen from the pads |
| mem_dout | output | 16 | Data driven toward the pads |
| mem_dout_en | output | 1 | Pad output enable for the data bus |
| mem_cs0_n | output | 1 | Even-byte SRAM select, active low |
| mem_cs1_n | output | 1 | Odd-byte SRAM select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Read strobe, active low |
| strap_cfg | output | 16 | Configuration captured from straps |

## Verification
The bench is tried with four kinds of traffic:
- **Word accesses.** Writes and reads with both lanes enabled and distinct byte values. A lane swap shows up as a wrong byte.
- **Single-lane writes.** A following word read exposes any disturbance of the lane that was not selected.
- **Single-lane reads.** The bench memory returns a garbage byte on the lane that is not selected, so a missing mask becomes visible.
- **Request edge cases.** An all-clear byte-enable request and a back-to-back request placed in the done cycle separate correct idle tracking from an off-by-one in the access counter.

Two resets with different strap patterns, followed by heavy bus traffic, tell apart strap capture at reset release from a register that keeps tracking the bus.

// File: rtl/dispmem_sram_if.sv
module dispmem_sram_if #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int ACC_CYCLES = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_be,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_din,
  output logic [DW-1:0] mem_dout,
  output logic          mem_dout_en,
  output logic          mem_cs0_n,
  output logic          mem_cs1_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] strap_cfg
);

  localparam int LANE = DW / 2;
  localparam int CW = $clog2(ACC_CYCLES + 1);

  logic          busy;
  logic [CW-1:0] cnt;
  logic          wr_q;
  logic [1:0]    be_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          start;
  logic [DW-1:0] rd_masked;

  assign start = req_valid && !busy && (req_be != 2'b00);

  assign rd_masked = {be_q[1] ? mem_din[DW-1:LANE] : {LANE{1'b0}},
                      be_q[0] ? mem_din[LANE-1:0]  : {LANE{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cnt     <= '0;
      done    <= 1'b0;
      rdata   <= '0;
      wr_q    <= 1'b0;
      be_q    <= 2'b00;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy    <= 1'b1;
        cnt     <= CW'(ACC_CYCLES - 1);
        wr_q    <= req_write;
        be_q    <= req_be;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end else if (busy) begin
        if (cnt == '0) begin
          busy  <= 1'b0;
          done  <= 1'b1;
          rdata <= wr_q ? '0 : rd_masked;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) strap_cfg <= mem_din;
  end

  assign req_ready   = !busy && !rst;
  assign mem_addr    = addr_q;
  assign mem_dout    = wdata_q;
  assign mem_dout_en = busy && wr_q && !rst;
  assign mem_cs0_n   = !(busy && be_q[0]);
  assign mem_cs1_n   = !(busy && be_q[1]);
  assign mem_we_n    = !(busy && wr_q);
  assign mem_oe_n    = !(busy && !wr_q);

  // assertions
  int unsigned chk_len;
  always_ff @(posedge clk) begin
    if (rst) chk_len <= 0;
    else if (start) chk_len <= 0;
    else if (busy) chk_len <= chk_len + 1;
  end

  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(!mem_we_n && !mem_oe_n));

  assert_strobe_needs_cs_R2: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n || !mem_oe_n) |-> (!mem_cs0_n || !mem_cs1_n));

  assert_drive_only_write_R4: assert property (@(posedge clk) disable iff (rst)
    mem_dout_en |-> (!mem_we_n && mem_oe_n));

  always_comb begin
    if (rst) assert_release_in_reset_R4: assert (!mem_dout_en);
  end

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_access_len_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (chk_len == ACC_CYCLES));

  assert_addr_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(mem_addr));

  assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(strap_cfg));

  assert_no_accept_busy_R11: assert property (@(posedge clk) disable iff (rst)
    !mem_cs0_n || !mem_cs1_n |-> !req_ready);

endmodule

// File: tb/tb_dispmem_sram_if.sv
module tb_dispmem_sram_if;
  localparam int ACC = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0] req_be = 2'b00;
  logic req_ready, done;
  logic [15:0] rdata, mem_addr, mem_din, mem_dout, strap_cfg;
  logic mem_dout_en, mem_cs0_n, mem_cs1_n, mem_we_n, mem_oe_n;
  logic [15:0] strap = 16'h0000;

  logic [7:0] lo [256];
  logic [7:0] hi [256];

  int n_chk = 0, n_bad = 0;

  dispmem_sram_if #(.AW(16), .DW(16), .ACC_CYCLES(ACC)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .req_ready(req_ready), .done(done), .rdata(rdata), .mem_addr(mem_addr),
    .mem_din(mem_din), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
    .mem_cs0_n(mem_cs0_n), .mem_cs1_n(mem_cs1_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .strap_cfg(strap_cfg));

  always_comb begin
    if (rst) mem_din = strap;
    else if (!mem_oe_n)
      mem_din = {mem_cs1_n ? 8'hEE : hi[mem_addr[7:0]],
                 mem_cs0_n ? 8'hEE : lo[mem_addr[7:0]]};
    else mem_din = 16'hD5A3;
  end

  always @(negedge clk) begin
    if (!mem_we_n && mem_dout_en) begin
      if (!mem_cs0_n) lo[mem_addr[7:0]] <= mem_dout[7:0];
      if (!mem_cs1_n) hi[mem_addr[7:0]] <= mem_dout[15:8];
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic do_reset(input logic [15:0] s);
    strap = s;
    rst = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(!mem_dout_en, "R4 bus released in reset", mem_dout_en, 0);
      check(mem_we_n && mem_oe_n && mem_cs0_n && mem_cs1_n, "R3 strobes idle in reset",
            {mem_we_n, mem_oe_n, mem_cs0_n, mem_cs1_n}, 4'hF);
    end
    rst = 1'b0;
    @(negedge clk);
    check(strap_cfg == s, "R5 strap capture", strap_cfg, s);
    check(req_ready, "R11 ready after reset", req_ready, 1);
  endtask

  // called at a negedge; returns at the negedge where done is seen
  task automatic access(input bit we, input logic [15:0] a, input logic [1:0] be,
                        input logic [15:0] wd, output logic [15:0] rd);
    int n;
    check(req_ready, "R11 ready before request", req_ready, 1);
    req_valid = 1'b1; req_write = we; req_addr = a; req_be = be; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R11 busy not ready", req_ready, 0);
    check(mem_cs0_n == !be[0] && mem_cs1_n == !be[1], "R2 chip selects",
          {mem_cs1_n, mem_cs0_n}, {~be[1], ~be[0]});
    check(mem_we_n == !we && mem_oe_n == we, "R3 strobes", {mem_we_n, mem_oe_n}, {~we, we});
    check(mem_dout_en == we, "R4 drive only on write", mem_dout_en, we);
    check(mem_addr == a, "R10 address", mem_addr, a);
    if (we) check(mem_dout == wd, "R1 write lanes", mem_dout, wd);
    n = 1;
    while (!done && n < 50) begin
      @(negedge clk);
      n++;
      if (!done) check(mem_addr == a, "R10 address held", mem_addr, a);
    end
    check(n == ACC + 1, "R7 access length", n, ACC + 1);
    check(mem_we_n && mem_oe_n && mem_cs0_n && mem_cs1_n, "R2 idle after access",
          {mem_we_n, mem_oe_n, mem_cs0_n, mem_cs1_n}, 4'hF);
    rd = rdata;
  endtask

  task automatic t_word();
    logic [15:0] rd;
    access(1'b1, 16'h0010, 2'b11, 16'hA55A, rd);
    check(rd == 16'h0000, "R8 rdata zero after write", rd, 0);
    @(negedge clk);
    check(!done, "R7 done one cycle", done, 0);
    check(lo[8'h10] == 8'h5A && hi[8'h10] == 8'hA5, "R1 lane placement",
          {hi[8'h10], lo[8'h10]}, 16'hA55A);
    access(1'b0, 16'h0010, 2'b11, 16'h0, rd);
    check(rd == 16'hA55A, "R8 word read", rd, 16'hA55A);
  endtask

  task automatic t_byte_write();
    logic [15:0] rd;
    access(1'b1, 16'h0020, 2'b11, 16'h1234, rd);
    access(1'b1, 16'h0020, 2'b01, 16'hFFCD, rd);
    access(1'b0, 16'h0020, 2'b11, 16'h0, rd);
    check(rd == 16'h12CD, "R2 even-only write", rd, 16'h12CD);
    access(1'b1, 16'h0020, 2'b10, 16'h77FF, rd);
    access(1'b0, 16'h0020, 2'b11, 16'h0, rd);
    check(rd == 16'h77CD, "R2 odd-only write", rd, 16'h77CD);
  endtask

  task automatic t_byte_read();
    logic [15:0] rd;
    access(1'b0, 16'h0020, 2'b10, 16'h0, rd);
    check(rd == 16'h7700, "R8 odd-only read masks even", rd, 16'h7700);
    access(1'b0, 16'h0020, 2'b01, 16'h0, rd);
    check(rd == 16'h00CD, "R8 even-only read masks odd", rd, 16'h00CD);
  endtask

  task automatic t_no_lanes();
    bit quiet = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0030; req_be = 2'b00; req_wdata = 16'hBEEF;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < ACC + 3; i++) begin
      if (done || !mem_cs0_n || !mem_cs1_n || !mem_we_n || !mem_oe_n || mem_dout_en) quiet = 1'b0;
      @(negedge clk);
    end
    check(quiet, "R9 empty byte enables ignored", quiet, 1);
    check(req_ready, "R9 still ready", req_ready, 1);
  endtask

  task automatic t_back_to_back();
    logic [15:0] rd;
    access(1'b1, 16'h0040, 2'b11, 16'hC3E1, rd);
    access(1'b0, 16'h0040, 2'b11, 16'h0, rd);
    check(rd == 16'hC3E1, "R11 back-to-back read", rd, 16'hC3E1);
  endtask

  initial begin
    #(8 * 20000);
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin lo[i] = 8'h00; hi[i] = 8'h00; end
    @(negedge clk);
    do_reset(16'h3C96);
    t_word();
    t_byte_write();
    t_byte_read();
    t_no_lanes();
    t_back_to_back();
    @(negedge clk);
    check(strap_cfg == 16'h3C96, "R6 cfg held through traffic", strap_cfg, 16'h3C96);
    do_reset(16'h81F0);
    t_word();
    check(strap_cfg == 16'h81F0, "R6 cfg held after second reset", strap_cfg, 16'h81F0);
    finish_run();
  end
endmodule